// File: doc/BRIEF.md
# Accumulating Observation Scan Chain with Serial Signature

This block is a chain of observation scan cells for logic self-test. Every cell watches a group of internal observe points, reduces the group to one observed bit through an XOR tree, and can fold that bit into its flop on every clock. Folding works while the chain shifts as well as while it captures, so fault effects are gathered on every cycle of a pattern and not only in the capture window.

Two controls choose each cell's behaviour. `scan_en` is the ordinary scan enable. `acc_en` turns accumulation on or off at run time. When `acc_en` is low, the chain is a plain scan chain. The last cell drives the serial output, which feeds a signature register on every shift cycle. The signature uses a fixed primitive polynomial and returns to a known seed on reset, so its value at the end of a session can be compared against an expected value.

Top module: `obs_scan_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all cells clear to 0 and the signature loads SEED (default 16'hACE1). From the next edge on, `scan_out` is 0 and `signature` equals SEED.
- R2: The observed bit of cell i is the XOR of `obs_pts[i*GROUP +: GROUP]`. Cell 0 is nearest `scan_in` and cell CELLS-1 drives `scan_out`.
- R3: With `scan_en`=0 and `acc_en`=0 (mission), each cell loads its observed bit.
- R4: With `scan_en`=0 and `acc_en`=1 (capture), each cell loads its observed bit XOR its own state. An all-zero group leaves the cell unchanged.
- R5: With `scan_en`=1 and `acc_en`=0 (plain shift), cell 0 loads `scan_in` and cell i loads cell i-1. The observe points have no effect.
- R6: With `scan_en`=1 and `acc_en`=1 (compaction), cell 0 loads observed XOR `scan_in`, and cell i loads observed XOR cell i-1.
- R7: `scan_out` is the flop of the last cell, so a bit entering at `scan_in` reaches `scan_out` CELLS edges later in plain shift.
- R8: On each edge with `scan_en`=1, the signature becomes (sig<<1) XOR (POLY if sig[SIG_W-1]) XOR `scan_out` placed in bit 0. POLY defaults to 16'h6801 (x^16+x^14+x^13+x^11+1). When `scan_en`=0, the signature holds.
- R9: `acc_en` may change on any cycle. Its value at an edge sets the behaviour for that edge only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset and session start |
| scan_en | input | 1 | Shift enable |
| acc_en | input | 1 | Accumulate enable |
| scan_in | input | 1 | Serial input to cell 0 |
| obs_pts | input | CELLS*GROUP | Grouped observe points, GROUP bits per cell |
| scan_out | output | 1 | Serial output (last cell) |
| signature | output | SIG_W | Signature register value |

## Verification
A bad cell state can only leave the block through `scan_out`. A fault in cell i therefore appears CELLS-1-i shift edges later, and one edge after that it is folded into the signature, where it stays for the rest of the session. The bench compares both outputs every cycle against a bit-level model of all four modes. A wrong mux leg, group mapping or feedback tap shows as a mismatch within at most CELLS+1 cycles. A sweep over every single observe point shows that each group is routed to the right cell.

// File: rtl/osc_pkg.sv
package osc_pkg;
  // Mode encoding is {scan_en, acc_en}
  typedef enum logic [1:0] {
    MODE_MISSION = 2'b00,
    MODE_CAPTURE = 2'b01,
    MODE_SHIFT   = 2'b10,
    MODE_COMPACT = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/obs_cell.sv
module obs_cell
  import osc_pkg::*;
#(
  parameter int GROUP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cell_mode_e       mode,
  input  logic [GROUP-1:0] obs,
  input  logic             si,
  output logic             q
);
  logic obs_bit;
  logic nxt;

  always_comb obs_bit = ^obs;

  always_comb begin
    case (mode)
      MODE_MISSION: nxt = obs_bit;
      MODE_CAPTURE: nxt = obs_bit ^ q;
      MODE_SHIFT:   nxt = si;
      default:      nxt = obs_bit ^ si;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  // R5
  plain_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SHIFT) |=> (q == $past(si)));

  // R4
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CAPTURE && obs == '0) |=> $stable(q));

  // R6
  compact_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_COMPACT && obs == '0) |=> (q == $past(si)));
endmodule

// File: rtl/obs_misr.sv
module obs_misr #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h6801,
  parameter logic [W-1:0]   SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] sig
);
  logic [W-1:0] fb;
  logic [W-1:0] nxt;

  always_comb begin
    fb  = sig[W-1] ? POLY : '0;
    nxt = {sig[W-2:0], 1'b0} ^ fb ^ {{(W-1){1'b0}}, din};
  end

  always_ff @(posedge clk) begin
    if (rst)     sig <= SEED;
    else if (en) sig <= nxt;
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sig));

  // R1
  seed_after_reset_chk: assert property (@(posedge clk)
    rst |=> (sig == SEED));
endmodule

// File: rtl/obs_scan_chain.sv
module obs_scan_chain
  import osc_pkg::*;
#(
  parameter int                CELLS = 8,
  parameter int                GROUP = 4,
  parameter int                SIG_W = 16,
  parameter logic [SIG_W-1:0]  POLY  = 16'h6801,
  parameter logic [SIG_W-1:0]  SEED  = 16'hACE1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scan_en,
  input  logic                   acc_en,
  input  logic                   scan_in,
  input  logic [CELLS*GROUP-1:0] obs_pts,
  output logic                   scan_out,
  output logic [SIG_W-1:0]       signature
);
  localparam int LAST = CELLS - 1;

  cell_mode_e       mode;
  logic [CELLS-1:0] q;

  always_comb mode = cell_mode_e'({scan_en, acc_en});

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic si_w;
    if (i == 0) begin : g_head
      always_comb si_w = scan_in;
    end else begin : g_link
      always_comb si_w = q[i-1];
    end
    obs_cell #(.GROUP(GROUP)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .obs  (obs_pts[i*GROUP +: GROUP]),
      .si   (si_w),
      .q    (q[i])
    );
  end

  always_comb scan_out = q[LAST];

  obs_misr #(.W(SIG_W), .POLY(POLY), .SEED(SEED)) u_misr (
    .clk (clk),
    .rst (rst),
    .en  (scan_en),
    .din (scan_out),
    .sig (signature)
  );

  // R7
  out_follows_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !acc_en) |=> (scan_out == $past(q[LAST-1 < 0 ? 0 : LAST-1])) || (CELLS == 1));
endmodule

// File: tb/obs_scan_chain_test.sv
module obs_scan_chain_test;
  localparam int CELLS = 8;
  localparam int GROUP = 4;
  localparam int SIG_W = 16;
  localparam logic [SIG_W-1:0] POLY = 16'h6801;
  localparam logic [SIG_W-1:0] SEED = 16'hACE1;
  localparam int NPTS = CELLS * GROUP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_en = 1'b0;
  logic acc_en = 1'b0;
  logic scan_in = 1'b0;
  logic [NPTS-1:0] obs_pts = '0;
  logic scan_out;
  logic [SIG_W-1:0] signature;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  bit m [CELLS];
  logic [SIG_W-1:0] esig;

  always #5 clk = ~clk;

  obs_scan_chain #(.CELLS(CELLS), .GROUP(GROUP), .SIG_W(SIG_W),
                   .POLY(POLY), .SEED(SEED)) uut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .acc_en(acc_en),
    .scan_in(scan_in), .obs_pts(obs_pts),
    .scan_out(scan_out), .signature(signature)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic se, input logic acc);
    case ({se, acc})
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a negedge; returns at the following negedge after checking
  task automatic step(input logic se, input logic acc, input logic si,
                      input logic [NPTS-1:0] o, input string tag);
    bit nm [CELLS];
    logic [SIG_W-1:0] ns;
    scan_en = se; acc_en = acc; scan_in = si; obs_pts = o;
    for (int i = 0; i < CELLS; i++) begin
      bit d;
      bit prev;
      d = ^o[i*GROUP +: GROUP];
      prev = (i == 0) ? si : m[i-1];
      case ({se, acc})
        2'b00:   nm[i] = d;
        2'b01:   nm[i] = d ^ m[i];
        2'b10:   nm[i] = prev;
        default: nm[i] = d ^ prev;
      endcase
    end
    if (se) ns = {esig[SIG_W-2:0], 1'b0} ^ (esig[SIG_W-1] ? POLY : '0)
                 ^ {{(SIG_W-1){1'b0}}, m[CELLS-1]};
    else    ns = esig;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < CELLS; i++) m[i] = nm[i];
    esig = ns;
    check(scan_out === m[CELLS-1], tag, 32'(scan_out), 32'(m[CELLS-1]));
    check(signature === esig, "R8", 32'(signature), 32'(esig));
  endtask

  function automatic logic [NPTS-1:0] rnd_obs();
    return NPTS'($urandom());
  endfunction

  initial begin
    for (int i = 0; i < CELLS; i++) m[i] = 1'b0;
    esig = SEED;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(scan_out === 1'b0, "R1", 32'(scan_out), 0);
    check(signature === SEED, "R1", 32'(signature), 32'(SEED));

    // R7: a one at scan_in is not visible after a single shift
    step(1'b1, 1'b0, 1'b1, '0, "R7");
    check(scan_out === 1'b0, "R7", 32'(scan_out), 0);
    for (int k = 0; k < CELLS - 1; k++) step(1'b1, 1'b0, 1'b0, rnd_obs(), "R7");

    // R2: each single observe point reaches its own cell
    for (int p = 0; p < NPTS; p++) begin
      step(1'b0, 1'b0, 1'b0, NPTS'(1) << p, "R2");
      for (int k = 0; k < CELLS; k++) step(1'b1, 1'b0, 1'b0, rnd_obs(), "R2");
    end

    // Per-mode sweeps
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 200; k++) begin
        logic se;
        logic acc;
        se = md[1]; acc = md[0];
        step(se, acc, 1'($urandom()), rnd_obs(), mode_tag(se, acc));
      end
    end

    // R4: all-zero groups in capture keep the state, then unload
    for (int k = 0; k < 10; k++) step(1'b0, 1'b1, 1'b0, '0, "R4");
    for (int k = 0; k < CELLS; k++) step(1'b1, 1'b0, 1'($urandom()), rnd_obs(), "R4");

    // R9: accumulate toggled every cycle
    for (int k = 0; k < 300; k++)
      step(1'($urandom()), k[0], 1'($urandom()), rnd_obs(), "R9");

    // Fully random session
    for (int k = 0; k < 2000; k++)
      step(1'($urandom()), 1'($urandom()), 1'($urandom()), rnd_obs(), "R6");

    // R8: final signature of the session
    check(signature === esig, "R8", 32'(signature), 32'(esig));

    // R1: reset mid-session restores seed
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < CELLS; i++) m[i] = 1'b0;
    esig = SEED;
    check(signature === SEED, "R1", 32'(signature), 32'(SEED));
    check(scan_out === 1'b0, "R1", 32'(scan_out), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule